// File: doc/BRIEF.md
# I2C Serial Memory Target

This block is an I2C target that answers on the bus like a small serial EEPROM. It samples SCL and SDA through a synchroniser on the system clock and detects START and STOP from the synchronised lines. It checks each control byte against a fixed device-type prefix and a 3-bit strap address. It then takes a word address of one or two bytes and either stores the following data bytes or streams stored bytes back to the master.

The block drives SDA only by pulling it low. The `sda_pull` output enables an open-drain pull-down, and the line reads high whenever both sides release it. The storage is an internal register array with a wrapping address pointer. A random read uses the usual sequence: an address write, then a repeated START, then a read control byte. Sequential reads continue for as long as the master acknowledges each byte.

The system clock must run at least 8 times faster than SCL.

Top module: `i2c_mem_target`

## Requirements
- R1: A START (SDA falls while SCL is high) restarts control-byte reception from any state, even in the middle of a byte. A STOP (SDA rises while SCL is high) returns the block to idle with SDA released, from any state.
- R2: `sda_pull` = 1 means the block pulls SDA low. The block never drives SDA high, and `sda_pull` changes only while SCL is low.
- R3: The control byte is received MSB first: bits 7..4 = 1010, bits 3..1 = `strap_addr`, bit 0 = R/W (1 = read). On a match the block pulls SDA low for the whole ninth clock.
- R4: A control byte with a wrong prefix or a wrong address gets no ACK. The block then ignores the bus until the next START: it drives no ACK and stores no data bytes.
- R5: With `wide_addr` = 0 the word address is one byte. With `wide_addr` = 1 it is two bytes, high byte first. Address bits above the array's index width are ignored. Every address byte is ACKed.
- R6: In a write, each data byte is ACKed and stored at the pointer, and the pointer then advances by one.
- R7: The pointer wraps from the last location (255) to 0, for both writes and reads.
- R8: After an address write, a repeated START and a read control byte make the block send, MSB first, the byte at that address. The byte for each SCL high is placed on SDA while SCL is low.
- R9: A master ACK on the ninth clock of a read byte makes the block send the next location. A master NACK makes the block release SDA and stay silent until the next START or STOP.
- R10: After reset SDA is released and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_addr | input | 3 | Device address compared with bits 3..1 of the control byte |
| wide_addr | input | 1 | 1 = two-byte word address, 0 = one byte |
| scl_in | input | 1 | Bus clock as seen on the pin |
| sda_in | input | 1 | Bus data as seen on the pin (wired-AND level) |
| sda_pull | output | 1 | Enable for the SDA pull-down |

## Verification
The bus lines pass through two synchroniser flops and one edge register before the state changes. A change on `sda_pull` therefore appears about four system cycles after the SCL fall that causes it, which is well inside the low half of an SCL period of 16 cycles. The bench master changes SDA four cycles into the low half and samples SDA four cycles into the high half, twelve cycles after the fall. By then every ACK bit and read bit the block owes has settled, and none of them has yet been released. A written byte is in the array on the cycle after its eighth bit completes, so the bench checks it through a later read transaction. The bench also watches `sda_pull` on every cycle while SCL is high to cover R2, and throughout the rejected transactions to cover R4.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

  // Device-type prefix carried in the top nibble of every control byte.
  localparam logic [3:0] DEV_PREFIX = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for START
    ST_RECV,   // shifting in a byte from the master
    ST_ACK,    // holding SDA low for the ninth clock
    ST_SEND,   // shifting out a stored byte
    ST_MACK    // sampling the master's ACK/NACK
  } link_state_t;

  typedef enum logic [1:0] {
    RB_CTRL,   // byte being received is a control byte
    RB_AHI,    // high word-address byte
    RB_ALO,    // low word-address byte
    RB_DATA    // write data byte
  } rx_role_t;

  function automatic logic ctrl_match(input logic [7:0] b, input logic [2:0] strap);
    return (b[7:4] == DEV_PREFIX) && (b[3:1] == strap);
  endfunction

  // Role of the next byte after an ACKed byte of a write.
  function automatic rx_role_t next_role(input rx_role_t r, input logic wide);
    case (r)
      RB_CTRL: return wide ? RB_AHI : RB_ALO;
      RB_AHI:  return RB_ALO;
      default: return RB_DATA;
    endcase
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  // An idle bus has both lines high, so every stage resets to one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // A bus condition needs SCL high on both samples around the SDA edge.
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_mem_store.sv
module i2c_mem_store #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  assign rd_data = cells[rd_addr];

endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target #(
  parameter int MEM_DEPTH   = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] strap_addr,
  input  logic       wide_addr,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_pull
);
  import i2c_mem_pkg::*;

  localparam int AW = $clog2(MEM_DEPTH);
  localparam logic [AW-1:0] LAST_LOC = AW'(MEM_DEPTH - 1);

  function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
    return (p == LAST_LOC) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [AW-1:0] ptr_from_word(input logic [7:0] hi, input logic [7:0] lo);
    return AW'({hi, lo});
  endfunction

  // Synchronised bus view
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt)
  );

  // Protocol state
  link_state_t   state;
  rx_role_t      role;
  logic [3:0]    bit_cnt;
  logic [7:0]    shreg;
  logic [7:0]    tx_sr;
  logic [7:0]    addr_hi;
  logic          rw_read;
  logic          mack_ok;
  logic [AW-1:0] ptr;
  logic [7:0]    mem_rd;

  // Named internal events
  logic byte_full;   // eighth bit has been received and its clock has ended
  logic ctrl_hit;    // received byte names this device
  logic store_en;    // a data byte is committed to the array
  logic mack_nack;   // master's ninth bit was a NACK and its clock has ended

  assign byte_full = (state == ST_RECV) && scl_fall && (bit_cnt == 4'd8);
  assign ctrl_hit  = ctrl_match(shreg, strap_addr);
  assign store_en  = byte_full && (role == RB_DATA);
  assign mack_nack = (state == ST_MACK) && scl_fall && !mack_ok;

  i2c_mem_store #(.DEPTH(MEM_DEPTH), .AW(AW)) u_store (
    .clk    (clk),
    .wr_en  (store_en),
    .wr_addr(ptr),
    .wr_data(shreg),
    .rd_addr(ptr),
    .rd_data(mem_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      role    <= RB_CTRL;
      bit_cnt <= '0;
      shreg   <= '0;
      tx_sr   <= '1;
      addr_hi <= '0;
      rw_read <= 1'b0;
      mack_ok <= 1'b0;
      ptr     <= '0;
    end else if (start_evt) begin
      state   <= ST_RECV;
      role    <= RB_CTRL;
      bit_cnt <= '0;
    end else if (stop_evt) begin
      state   <= ST_IDLE;
    end else begin
      case (state)
        ST_RECV: begin
          if (scl_rise && bit_cnt != 4'd8) begin
            shreg   <= {shreg[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (byte_full) begin
            bit_cnt <= '0;
            if (role == RB_CTRL && !ctrl_hit) begin
              state <= ST_IDLE;
            end else begin
              state <= ST_ACK;
              case (role)
                RB_CTRL: rw_read <= shreg[0];
                RB_AHI:  addr_hi <= shreg;
                RB_ALO:  ptr     <= ptr_from_word(wide_addr ? addr_hi : 8'h00, shreg);
                default: ptr     <= ptr_step(ptr);
              endcase
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (role == RB_CTRL && rw_read) begin
              tx_sr   <= mem_rd;
              ptr     <= ptr_step(ptr);
              bit_cnt <= '0;
              state   <= ST_SEND;
            end else begin
              role  <= next_role(role, wide_addr);
              state <= ST_RECV;
            end
          end
        end
        ST_SEND: begin
          if (scl_fall) begin
            if (bit_cnt == 4'd7) begin
              state <= ST_MACK;
            end else begin
              tx_sr   <= {tx_sr[6:0], 1'b1};
              bit_cnt <= bit_cnt + 4'd1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_ok <= ~sda_s;
          end else if (scl_fall) begin
            if (mack_ok) begin
              tx_sr   <= mem_rd;
              ptr     <= ptr_step(ptr);
              bit_cnt <= '0;
              state   <= ST_SEND;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Open-drain pull enable: only ever a low level
  assign sda_pull = (state == ST_ACK) || ((state == ST_SEND) && !tx_sr[7]);

  // Assertions

  // R1: a START always restarts control-byte reception
  p_start_restarts_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (state == ST_RECV) && (role == RB_CTRL) && (bit_cnt == 4'd0));

  // R1: a STOP always releases the line
  p_stop_releases_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_pull);

  // R2: the pull enable stays put while synchronised SCL is high
  p_quiet_while_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_pull));

  // R4: a control byte for another device is never ACKed
  p_mismatch_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_full && role == RB_CTRL && !ctrl_hit) |=> (state == ST_IDLE) && !sda_pull);

  // R7: the pointer wraps after a write at the last location
  p_ptr_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (store_en && ptr == LAST_LOC) |=> (ptr == '0));

  // R9: a master NACK releases the line and idles the block
  p_nack_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mack_nack |=> (state == ST_IDLE) && !sda_pull);

endmodule

// File: tb/i2c_mem_target_test.sv
module i2c_mem_target_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] strap = 3'b101;
  logic       wide;
  logic       scl_m;
  logic       m_low;
  logic       sda_pull;
  logic       sda_line;

  always #10 clk = ~clk;   // 50 MHz

  assign sda_line = ~(m_low | sda_pull);

  i2c_mem_target uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap_addr(strap),
    .wide_addr (wide),
    .scl_in    (scl_m),
    .sda_in    (sda_line),
    .sda_pull  (sda_pull)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // Scoreboard queues
  string q_req[$];
  int    q_val[$];
  int    obs_q[$];

  logic [7:0] model [256];
  logic [7:0] wbuf[$];

  int  r2_viol = 0;
  int  r4_viol = 0;
  bit  watch_silent = 0;
  logic prev_pull = 1'b0;

  task automatic check(input string r, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", r, got, exp);
    end
  endtask

  task automatic expect_item(input string r, input int v);
    q_req.push_back(r);
    q_val.push_back(v);
  endtask

  // Monitor: pairs every observed bus result with the oldest expectation
  initial begin
    forever begin
      @(negedge clk);
      while (obs_q.size() > 0) begin
        int got;
        got = obs_q.pop_front();
        if (q_req.size() == 0) begin
          check("unexpected item", got, -1);
        end else begin
          string r;
          int    e;
          r = q_req.pop_front();
          e = q_val.pop_front();
          check(r, got, e);
        end
      end
    end
  end

  // R2 / R4 line monitors
  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_m && (sda_pull != prev_pull)) r2_viol++;
      if (watch_silent && sda_pull) r4_viol++;
    end
    prev_pull <= sda_pull;
  end

  // Bus master
  task automatic qtr();
    repeat (4) @(negedge clk);
  endtask

  task automatic clock_bit(input logic drive_low, output logic seen);
    qtr(); m_low = drive_low;
    qtr(); scl_m = 1'b1;
    qtr(); seen = sda_line;
    qtr(); scl_m = 1'b0;
  endtask

  task automatic bus_start();
    qtr(); m_low = 1'b0;
    qtr(); scl_m = 1'b1;
    qtr(); m_low = 1'b1;
    qtr(); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    qtr(); m_low = 1'b1;
    qtr(); scl_m = 1'b1;
    qtr(); m_low = 1'b0;
    qtr();
  endtask

  task automatic send_byte(input logic [7:0] b, input string r, input int exp_ack);
    logic s;
    expect_item(r, exp_ack);
    for (int i = 7; i >= 0; i--) clock_bit(~b[i], s);
    clock_bit(1'b0, s);
    obs_q.push_back(int'(s));
  endtask

  task automatic read_byte(input string r, input logic [7:0] exp, input logic ack);
    logic [7:0] v;
    logic s;
    expect_item(r, exp);
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b0, s);
      v[i] = s;
    end
    obs_q.push_back(int'(v));
    clock_bit(ack, s);
  endtask

  task automatic send_word(input logic [15:0] wa, input string r);
    if (wide) send_byte(wa[15:8], r, 0);
    send_byte(wa[7:0], r, 0);
  endtask

  task automatic write_txn(input logic [15:0] wa, input string r);
    logic [7:0] idx;
    idx = wa[7:0];
    bus_start();
    send_byte({4'b1010, strap, 1'b0}, "R3", 0);
    send_word(wa, "R5");
    foreach (wbuf[i]) begin
      send_byte(wbuf[i], r, 0);
      model[idx] = wbuf[i];
      idx = idx + 8'd1;
    end
    bus_stop();
  endtask

  task automatic read_txn(input logic [15:0] wa, input int n, input string r);
    logic [7:0] idx;
    idx = wa[7:0];
    bus_start();
    send_byte({4'b1010, strap, 1'b0}, "R3", 0);
    send_word(wa, "R5");
    bus_start();
    send_byte({4'b1010, strap, 1'b1}, "R3", 0);
    for (int i = 0; i < n; i++) begin
      read_byte(r, model[idx], (i < n - 1));
      idx = idx + 8'd1;
    end
    bus_stop();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic s;
    logic [7:0] v;
    rst_n = 1'b0;
    wide  = 1'b0;
    scl_m = 1'b1;
    m_low = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R10: released and idle after reset
    check("R10 pull after reset", int'(sda_pull), 0);
    check("R10 line after reset", int'(sda_line), 1);

    // R6/R8: one-byte address write then random read
    wbuf = '{8'h11, 8'h22, 8'h33};
    write_txn(16'h0010, "R6");
    read_txn(16'h0010, 3, "R8");

    // R7: wrap at the top of the array
    wbuf = '{8'hA1, 8'hA2, 8'hA3};
    write_txn(16'h00FE, "R7");
    read_txn(16'h00FE, 3, "R7");

    // R4: wrong address, then wrong prefix; nothing is ACKed or stored
    bus_start();
    send_byte({4'b1010, 3'b001, 1'b0}, "R4", 1);
    watch_silent = 1;
    send_byte(8'h10, "R4", 1);
    send_byte(8'h55, "R4", 1);
    bus_stop();
    bus_start();
    send_byte({4'b0010, strap, 1'b0}, "R4", 1);
    send_byte(8'h10, "R4", 1);
    send_byte(8'h66, "R4", 1);
    bus_stop();
    watch_silent = 0;
    read_txn(16'h0010, 1, "R4");

    // R5: two-byte address; bits above the array width ignored
    wide = 1'b1;
    wbuf = '{8'h5A, 8'h6B};
    write_txn(16'h7F20, "R5");
    read_txn(16'h0020, 2, "R5");
    wide = 1'b0;
    read_txn(16'h0020, 1, "R5");

    // R9: after a NACK the block stays silent while clocks continue
    read_txn(16'h0011, 2, "R9");
    bus_start();
    send_byte({4'b1010, strap, 1'b0}, "R3", 0);
    send_byte(8'h10, "R9", 0);
    bus_start();
    send_byte({4'b1010, strap, 1'b1}, "R9", 0);
    read_byte("R9", model[8'h10], 1'b0);
    expect_item("R9 silent after NACK", 8'hFF);
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b0, s);
      v[i] = s;
    end
    obs_q.push_back(int'(v));
    bus_stop();

    // R1: START in the middle of an address byte restarts reception
    bus_start();
    send_byte({4'b1010, strap, 1'b0}, "R1", 0);
    for (int i = 0; i < 4; i++) clock_bit(i[0], s);
    read_txn(16'h0012, 1, "R1");

    repeat (20) @(negedge clk);
    check("R2 pull changes while SCL high", r2_viol, 0);
    check("R4 pull during rejected transaction", r4_viol, 0);
    check("all expected items seen", q_req.size(), 0);
    finish_run();
  end

endmodule